// File: doc/BRIEF.md
# Minimal 16-bit Load-Store Processor Core

This block is a small multicycle processor core meant for teaching. It reads fixed-width 16-bit instructions from a byte-addressed memory of 4096 bytes and executes four operations. Two of them move data between the memory and the registers (load and store). The other two combine two registers (addition and exclusive OR). The core holds eight 16-bit general registers, an instruction pointer and a flags register. Every operand is a register index, and memory is reached only through the load and store operations.

The core talks to one synchronous memory port. The port carries a 12-bit byte address, a 16-bit write data word, a write enable, a 16-bit read data word and a flag that marks instruction fetches. The memory returns read data one cycle after it samples an address.

An instruction word holds an opcode in bits 15..8, a first register index in bits 7..4 and a second register index in bits 3..0. When the core meets an opcode it does not know, or a register index that names no register, it stops. It then holds its halt and illegal-instruction outputs high until reset.

Top module: `lsc_core`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the core presents a fetch at address 0x000 with `mem_is_fetch`=1, `mem_we`=0, `halted`=0, `illegal`=0 and `flags_o`=0. Reset also clears all general registers to zero.
- R2: Memory words are 16 bits and little-endian: the low byte sits at the even address and the high byte at the next address. The core only drives even addresses. An instruction takes its opcode from bits 15..8, its first index (op0) from bits 7..4 and its second index (op1) from bits 3..0.
- R3: Opcode 0x00 loads the word at address {op1[11:1],0} into op0. The address uses only the low 12 bits of op1, with bit 0 forced to zero.
- R4: Opcode 0x01 stores op0 to address {op1[11:1],0}. `mem_we` is high for exactly one cycle, with `mem_is_fetch`=0 and `mem_wdata` equal to the value of op0.
- R5: Opcode 0x02 writes op0 + op1 (modulo 2^16) into op0.
- R6: Opcode 0x03 writes op0 XOR op1 into op0.
- R7: `flags_o` uses bit 0 for zero, bit 1 for carry and bit 2 for signed overflow. Bits 15..3 are always 0. Addition sets all three flags. Exclusive OR sets zero and clears carry and overflow. Load and store leave the flags unchanged. A new flag value appears in the cycle after the execute cycle.
- R8: After each legal instruction, the next fetch address is the previous one plus 2, taken modulo 4096, so 0xFFE is followed by 0x000.
- R9: Addition and exclusive OR take two cycles: fetch, then execute. Load and store take three cycles: fetch, execute, then a data cycle with `mem_is_fetch`=0. The core always goes back to fetching after a data cycle.
- R10: An opcode above 0x03 sets `halted` and `illegal` in the cycle after its execute cycle. Both stay high until reset, and after that the port shows no fetch and no write. No register or flag changes.
- R11: A register index field above 7 in either operand halts the core in the same way as R10, even when the opcode is legal. A store with such an index writes nothing.
- R12: A value loaded by one instruction can be used by the next instruction as a data operand or as an address, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (12) | Byte address of the current memory access, always even |
| mem_wdata | output | DATA_W (16) | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_is_fetch | output | 1 | 1 when the access is an instruction fetch, 0 when it is a data access or the core is halted |
| mem_rdata | input | DATA_W (16) | Read data, valid one cycle after the address |
| flags_o | output | DATA_W (16) | Flags register: zero in bit 0, carry in bit 1, overflow in bit 2 |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | The core stopped because of an illegal instruction |

## Verification
The register write that completes a load is done in the same cycle as the fetch of the next instruction. Both use the single read-data port, one after the other. The test provokes this overlap with a chain of back-to-back loads, where each load takes its address from the register the previous load has just filled. A later store writes back a freshly loaded value. A cycle-by-cycle reference model in the bench judges the result: it compares the next data address, the stored word and the fetch address in every cycle, so a late or misdirected writeback shows up as a wrong address or a wrong data word.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // ISA encoding widths
  localparam int INSN_W   = 16;
  localparam int OPC_W    = 8;
  localparam int IDX_W    = 4;
  localparam int FLAG_CNT = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h00;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'h01;
  localparam logic [OPC_W-1:0] OPC_ADD   = 8'h02;
  localparam logic [OPC_W-1:0] OPC_XOR   = 8'h03;

  // flag bit positions
  localparam int FL_Z = 0;
  localparam int FL_C = 1;
  localparam int FL_V = 2;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_MEM   = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;

  typedef struct packed {
    logic is_ld;
    logic is_st;
    logic is_add;
    logic is_xor;
    logic bad;
  } op_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
  import lsc_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic [INSN_W-1:0] insn,
  output op_t               op,
  output logic [RA_W-1:0]   dst_idx,
  output logic [RA_W-1:0]   src_idx
);

  logic [OPC_W-1:0] opc;
  logic [IDX_W-1:0] fld_dst;
  logic [IDX_W-1:0] fld_src;
  logic             idx_bad;
  logic             opc_bad;

  assign opc     = insn[INSN_W-1 -: OPC_W];
  assign fld_dst = insn[2*IDX_W-1 -: IDX_W];
  assign fld_src = insn[IDX_W-1:0];
  assign idx_bad = (int'(fld_dst) >= NREG) || (int'(fld_src) >= NREG);
  assign dst_idx = fld_dst[RA_W-1:0];
  assign src_idx = fld_src[RA_W-1:0];

  always_comb begin
    op      = '0;
    opc_bad = 1'b0;
    case (opc)
      OPC_LOAD:  op.is_ld  = 1'b1;
      OPC_STORE: op.is_st  = 1'b1;
      OPC_ADD:   op.is_add = 1'b1;
      OPC_XOR:   op.is_xor = 1'b1;
      default:   opc_bad   = 1'b1;
    endcase
    op.bad = opc_bad | idx_bad;
    if (op.bad) begin
      op.is_ld  = 1'b0;
      op.is_st  = 1'b0;
      op.is_add = 1'b0;
      op.is_xor = 1'b0;
    end
  end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [RA_W-1:0]   rd_idx_a,
  input  logic [RA_W-1:0]   rd_idx_b,
  output logic [DATA_W-1:0] rd_val_a,
  output logic [DATA_W-1:0] rd_val_b
);

  logic [NREG-1:0][DATA_W-1:0] bank;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_idx == RA_W'(i))) begin
        q <= wr_val;
      end
    end
    assign bank[i] = q;
  end

  assign rd_val_a = bank[rd_idx_a];
  assign rd_val_b = bank[rd_idx_b];

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  input  logic                sel_xor,
  output logic [DATA_W-1:0]   res,
  output logic [FLAG_CNT-1:0] flg
);

  logic [DATA_W:0] sum;

  assign sum = {1'b0, lhs} + {1'b0, rhs};

  always_comb begin
    flg = '0;
    if (sel_xor) begin
      res = lhs ^ rhs;
    end else begin
      res       = sum[DATA_W-1:0];
      flg[FL_C] = sum[DATA_W];
      flg[FL_V] = (lhs[DATA_W-1] == rhs[DATA_W-1]) && (res[DATA_W-1] != lhs[DATA_W-1]);
    end
    flg[FL_Z] = (res == '0);
  end

endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int NREG   = 8,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_is_fetch,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] flags_o,
  output logic              halted,
  output logic              illegal
);

  localparam logic [ADDR_W-1:0] IP_STEP = ADDR_W'(2);

  phase_e              phase_q;
  logic [ADDR_W-1:0]   ip_q;
  logic [ADDR_W-1:0]   ip_next;
  logic [FLAG_CNT-1:0] flags_q;
  logic                is_load_q;
  logic                ld_pend_q;
  logic [RA_W-1:0]     ld_dst_q;

  op_t                 dec_op;
  logic [RA_W-1:0]     dst_idx;
  logic [RA_W-1:0]     src_idx;

  logic                rf_we;
  logic [RA_W-1:0]     rf_widx;
  logic [DATA_W-1:0]   rf_wval;
  logic [DATA_W-1:0]   val_a;
  logic [DATA_W-1:0]   val_b;

  logic [DATA_W-1:0]   alu_res;
  logic [FLAG_CNT-1:0] alu_flg;

  lsc_decode #(.NREG(NREG)) u_dec (
    .insn    (mem_rdata[INSN_W-1:0]),
    .op      (dec_op),
    .dst_idx (dst_idx),
    .src_idx (src_idx)
  );

  lsc_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rf_we),
    .wr_idx   (rf_widx),
    .wr_val   (rf_wval),
    .rd_idx_a (dst_idx),
    .rd_idx_b (src_idx),
    .rd_val_a (val_a),
    .rd_val_b (val_b)
  );

  lsc_alu #(.DATA_W(DATA_W)) u_alu (
    .lhs     (val_a),
    .rhs     (val_b),
    .sel_xor (dec_op.is_xor),
    .res     (alu_res),
    .flg     (alu_flg)
  );

  // Load writeback shares the fetch cycle; ALU writeback happens in execute.
  always_comb begin
    if (phase_q == PH_FETCH) begin
      rf_we   = ld_pend_q;
      rf_widx = ld_dst_q;
      rf_wval = mem_rdata;
    end else begin
      rf_we   = (phase_q == PH_EXEC) && (dec_op.is_add || dec_op.is_xor);
      rf_widx = dst_idx;
      rf_wval = alu_res;
    end
  end

  assign ip_next = ip_q + IP_STEP;
  assign flags_o = {{(DATA_W-FLAG_CNT){1'b0}}, flags_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_FETCH;
      ip_q         <= '0;
      flags_q      <= '0;
      is_load_q    <= 1'b0;
      ld_pend_q    <= 1'b0;
      ld_dst_q     <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_we       <= 1'b0;
      mem_is_fetch <= 1'b1;
      halted       <= 1'b0;
      illegal      <= 1'b0;
    end else begin
      case (phase_q)
        PH_FETCH: begin
          ld_pend_q <= 1'b0;
          phase_q   <= PH_EXEC;
        end
        PH_EXEC: begin
          if (dec_op.bad) begin
            phase_q      <= PH_HALT;
            halted       <= 1'b1;
            illegal      <= 1'b1;
            mem_is_fetch <= 1'b0;
          end else if (dec_op.is_add || dec_op.is_xor) begin
            ip_q     <= ip_next;
            flags_q  <= alu_flg;
            mem_addr <= ip_next;
            phase_q  <= PH_FETCH;
          end else begin
            ip_q         <= ip_next;
            mem_addr     <= {val_b[ADDR_W-1:1], 1'b0};
            mem_wdata    <= val_a;
            mem_we       <= dec_op.is_st;
            mem_is_fetch <= 1'b0;
            is_load_q    <= dec_op.is_ld;
            ld_dst_q     <= dst_idx;
            phase_q      <= PH_MEM;
          end
        end
        PH_MEM: begin
          mem_we       <= 1'b0;
          mem_is_fetch <= 1'b1;
          mem_addr     <= ip_q;
          ld_pend_q    <= is_load_q;
          phase_q      <= PH_FETCH;
        end
        default: begin
          phase_q <= PH_HALT;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_is_fetch,
  input logic [DATA_W-1:0] flags_o,
  input logic              halted,
  input logic              illegal
);

  assert_even_addr_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_addr[0]);

  assert_store_single_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_store_is_data_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_is_fetch);

  assert_flags_high_zero_R7: assert property (@(posedge clk) disable iff (rst)
    flags_o[DATA_W-1:3] == '0);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_is_fetch |=> $stable(flags_o));

  assert_back_to_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_is_fetch && !halted) |=> mem_is_fetch);

  assert_fetch_two_cycles_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_is_fetch) |=> mem_is_fetch);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && illegal));

  assert_halt_flag_pair_R10: assert property (@(posedge clk) disable iff (rst)
    illegal == halted);

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !mem_is_fetch));

endmodule

bind lsc_core lsc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_is_fetch (mem_is_fetch),
  .flags_o      (flags_o),
  .halted       (halted),
  .illegal      (illegal)
);

// File: tb/lsc_core_tb.sv
`timescale 1ns/1ps
module lsc_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        mem_is_fetch;
  logic [15:0] mem_rdata = '0;
  logic [15:0] flags_o;
  logic        halted;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  lsc_core u_dut (
    .clk          (clk),
    .rst          (rst),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .mem_is_fetch (mem_is_fetch),
    .mem_rdata    (mem_rdata),
    .flags_o      (flags_o),
    .halted       (halted),
    .illegal      (illegal)
  );

  // behavioural byte memory seen by the core (writes applied by the main process)
  logic [7:0] bmem [4096];
  always @(posedge clk) begin
    mem_rdata <= {bmem[{mem_addr[11:1], 1'b1}], bmem[{mem_addr[11:1], 1'b0}]};
  end

  // reference model state
  logic [7:0]  mm [4096];
  logic [15:0] mr [8];
  string       mt [8];
  int          ph;          // 0 fetch, 1 exec, 2 data, 3 halt
  logic [15:0] mip, mfl, minsn, daddr, wval, ldval;
  bit          m_st, pend;
  int          pdst, ldst, prev_ld;
  string       atag, wtag, htag;

  function automatic logic [15:0] mword(logic [15:0] a);
    int e = int'(a & 16'h0FFE);
    return {mm[e+1], mm[e]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(int a, logic [15:0] w);
    bmem[a] = w[7:0]; bmem[a+1] = w[15:8];
    mm[a]   = w[7:0]; mm[a+1]   = w[15:8];
  endtask

  task automatic fill(logic [15:0] w);
    for (int i = 0; i < 4096; i += 2) put(i, w);
  endtask

  task automatic compare(int cyc);
    bit hx = (ph == 3);
    chk(halted === hx, hx ? htag : "R10", "halted", {15'b0, halted}, {15'b0, hx});
    chk(illegal === hx, hx ? htag : "R11", "illegal", {15'b0, illegal}, {15'b0, hx});
    chk(flags_o === mfl, "R7", "flags", flags_o, mfl);
    case (ph)
      0: begin
        chk(mem_addr === mip[11:0], (cyc == 0) ? "R1 R8" : "R2 R8", "fetch address",
            {4'b0, mem_addr}, mip);
        chk(mem_is_fetch === 1'b1, "R9", "fetch marker", {15'b0, mem_is_fetch}, 16'd1);
        chk(mem_we === 1'b0, "R9", "write in fetch", {15'b0, mem_we}, 16'd0);
      end
      1: chk(mem_we === 1'b0, "R9", "write in execute", {15'b0, mem_we}, 16'd0);
      2: begin
        chk(mem_addr === daddr[11:0], atag, "data address", {4'b0, mem_addr}, daddr);
        chk(mem_is_fetch === 1'b0, "R9", "data marker", {15'b0, mem_is_fetch}, 16'd0);
        chk(mem_we === m_st, "R4", "write strobe", {15'b0, mem_we}, {15'b0, m_st});
        if (m_st) chk(mem_wdata === wval, wtag, "store data", mem_wdata, wval);
      end
      default: begin
        chk(mem_we === 1'b0, htag, "write after halt", {15'b0, mem_we}, 16'd0);
        chk(mem_is_fetch === 1'b0, htag, "fetch after halt", {15'b0, mem_is_fetch}, 16'd0);
      end
    endcase
  endtask

  task automatic step();
    int opc, a, b;
    logic [16:0] s;
    logic [15:0] rv;
    string pre;
    case (ph)
      0: begin
        prev_ld = -1;
        if (pend) begin
          mr[pdst] = ldval; mt[pdst] = "R3"; prev_ld = pdst; pend = 0;
        end
        minsn = mword(mip);
        ph = 1;
      end
      1: begin
        opc = int'(minsn[15:8]); a = int'(minsn[7:4]); b = int'(minsn[3:0]);
        if (opc > 3) begin
          ph = 3; htag = "R10";
        end else if (a > 7 || b > 7) begin
          ph = 3; htag = "R11";
        end else begin
          pre = (a == prev_ld || b == prev_ld) ? "R12 " : "";
          mip = (mip + 16'd2) & 16'h0FFF;
          if (opc == 2) begin
            s  = {1'b0, mr[a]} + {1'b0, mr[b]};
            rv = s[15:0];
            mfl = {13'b0, (mr[a][15] == mr[b][15]) && (rv[15] != mr[a][15]), s[16], rv == 16'h0};
            mr[a] = rv; mt[a] = {pre, "R5"}; ph = 0;
          end else if (opc == 3) begin
            rv = mr[a] ^ mr[b];
            mfl = {15'b0, rv == 16'h0};
            mr[a] = rv; mt[a] = {pre, "R6"}; ph = 0;
          end else begin
            m_st  = (opc == 1);
            daddr = mr[b] & 16'h0FFE;
            wval  = mr[a];
            ldst  = a;
            atag  = {pre, m_st ? "R4" : "R3"};
            wtag  = (a == prev_ld) ? {"R12 ", mt[a]} : mt[a];
            ph = 2;
          end
        end
      end
      2: begin
        if (m_st) begin
          mm[int'(daddr)] = wval[7:0]; mm[int'(daddr)+1] = wval[15:8];
        end else begin
          ldval = mword(daddr); pend = 1; pdst = ldst;
        end
        ph = 0;
      end
      default: ph = 3;
    endcase
  endtask

  task automatic run_prog(int ncyc);
    rst = 1'b1;
    for (int i = 0; i < 8; i++) begin mr[i] = '0; mt[i] = "R1"; end
    ph = 0; mip = '0; mfl = '0; pend = 0; prev_ld = -1; m_st = 0; htag = "R10";
    repeat (3) @(negedge clk);
    chk(mem_is_fetch === 1'b1 && mem_we === 1'b0, "R1", "reset port state",
        {14'b0, mem_is_fetch, mem_we}, 16'd2);
    chk(halted === 1'b0 && illegal === 1'b0, "R1", "reset halt state",
        {14'b0, halted, illegal}, 16'd0);
    chk(flags_o === 16'h0 && mem_addr === 12'h0, "R1", "reset flags/address", flags_o, 16'h0);
    rst = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      compare(c);
      if (mem_we === 1'b1) begin
        bmem[{mem_addr[11:1], 1'b0}] = mem_wdata[7:0];
        bmem[{mem_addr[11:1], 1'b1}] = mem_wdata[15:8];
      end
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    // program 1: load chain, arithmetic, flags, stores, store-then-load
    fill(16'h0000);
    put(12'h000, 16'h0040); put(12'h002, 16'h0024); put(12'h004, 16'h0032);
    put(12'h006, 16'h0013); put(12'h008, 16'h0051); put(12'h00A, 16'h0065);
    put(12'h00C, 16'h0256); put(12'h00E, 16'h0256); put(12'h010, 16'h0211);
    put(12'h012, 16'h0366); put(12'h014, 16'h0334); put(12'h016, 16'h0134);
    put(12'h018, 16'h0152); put(12'h01A, 16'h0074); put(12'h01C, 16'h0172);
    put(12'h01E, 16'h0115); put(12'h020, 16'h0233); put(12'h022, 16'h0134);
    put(12'h024, 16'h0332); put(12'h026, 16'h0134); put(12'h028, 16'hFF00);
    put(12'h040, 16'h0100); put(12'h100, 16'h7102); put(12'h102, 16'h8105);
    put(12'h104, 16'hFFFE); put(12'hFFE, 16'h0001);
    run_prog(100);

    // program 2: store with register index 8 in op1 (R11)
    fill(16'h0000);
    put(12'h000, 16'h0040); put(12'h002, 16'h0148); put(12'h040, 16'h1234);
    run_prog(24);

    // program 3: add then unknown opcode 0x04 (R10)
    fill(16'h0000);
    put(12'h000, 16'h0240); put(12'h002, 16'h0400);
    run_prog(24);

    // program 4: straight-line adds across the 0xFFE -> 0x000 wrap (R8)
    fill(16'h0211);
    run_prog(2 * 2048 + 40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule